// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a direct-mapped data cache that sits between a processor load/store port and a lower-level memory. Each line holds four 32-bit words. A 32-bit byte address is split into a tag, a line index, a word select and a byte offset. A lookup hits when the indexed line is valid and its stored tag equals the address tag. The word is then picked from the line by the word-select bits.

Any access that misses stalls the processor while the whole line is fetched. The fetch is four sequential word reads, each with a request handshake followed by a response. A write follows write-through: it updates the cached word and hands the same word to a downstream write port, normally a write buffer. A write miss first fetches the line and only then merges and forwards the word. After a fill the access is retried internally as a hit, so read misses and write misses end the same way as the corresponding hits.

The processor keeps its request stable while stall is high. Load data and the hit flag are valid in the cycle stall is low.

Top module: `wt_dm_cache`

## Requirements
- R1: Address bits [31:16] are the tag, [15:4] the line index, [3:2] the word select and [1:0] the byte offset. Every fill read address equals {tag, index, word, 2'b00} of the missing access.
- R2: After reset every line is invalid. The first access to any address stalls with hit low and issues a fill.
- R3: A read that hits has stall low and hit high in the cycle it is presented. Its read data is the word selected by address bits [3:2].
- R4: On a miss, stall stays high while the line is fetched. Words 0, 1, 2, 3 are requested in ascending order, one outstanding read at a time. A request is held stable until it is accepted.
- R5: When the stall for a read miss drops, hit is high and the read data equals the lower-memory word at the requested address.
- R6: An access whose tag differs from the one stored at its index misses and refills that line. The displaced line then misses again.
- R7: A write that hits offers {addr[31:2], 2'b00} and the write data on the write port. It stalls until that port is ready, then updates only the addressed word of the line.
- R8: A write that misses forwards nothing until all four words of the line have arrived. It then merges the word into the line and forwards it. A later read of that word hits and returns the written value.
- R9: The byte offset bits [1:0] have no effect: addresses differing only in them return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor access request, held while stalled |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Store data |
| cpu_stall_o | output | 1 | Request cannot complete this cycle |
| cpu_hit_o | output | 1 | Lookup hit, valid when stall is low |
| cpu_rdata_o | output | 32 | Load data, valid when stall is low |
| mem_rd_valid_o | output | 1 | Fill word read request |
| mem_rd_addr_o | output | 32 | Fill word address |
| mem_rd_ready_i | input | 1 | Lower memory accepts the read request |
| mem_rdata_valid_i | input | 1 | Read response strobe |
| mem_rdata_i | input | 32 | Read response data |
| mem_wr_valid_o | output | 1 | Write-through word offered |
| mem_wr_addr_o | output | 32 | Write-through word address |
| mem_wr_data_o | output | 32 | Write-through data |
| mem_wr_ready_i | input | 1 | Downstream write port accepts |

## Verification
Cold reads are compared against warm reads of other words in the same line. The cold reads must show a four-word ascending fill and a stall; the warm reads must show no stall, which separates the fill path from the lookup path. Two tags sharing one index are alternated to show that the tag compare, not only the valid bit, decides a hit. Write hits with a delayed write port show stalling on the downstream handshake, and reading the neighbouring words shows that only one word changed. A write to a cold line shows that the fill precedes the forwarded write. Addresses that differ only in the byte offset show that those bits are ignored.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fill_state_e;
endpackage

// File: rtl/wtc_word_mux.sv
module wtc_word_mux #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2,
  localparam int WORDS  = 1 << SEL_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_split
    assign words[w] = line_i[w*DATA_W +: DATA_W];
  end

  assign word_o = words[sel_i];
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int IDX_W  = 12,
  parameter int TAG_W  = 16,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2,
  localparam int WORDS  = 1 << SEL_W,
  localparam int LINE_W = WORDS * DATA_W,
  localparam int LINES  = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // lookup, combinational
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [SEL_W-1:0]  lk_sel_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_word_o,
  // single word update at the lookup position
  input  logic              wr_word_en_i,
  input  logic [DATA_W-1:0] wr_word_data_i,
  // whole line install
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_line_i
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [LINE_W-1:0] data_mem [LINES];
  logic [LINE_W-1:0] lk_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (fill_en_i) valid_q[fill_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_mem[fill_idx_i]  <= fill_tag_i;
      data_mem[fill_idx_i] <= fill_line_i;
    end else if (wr_word_en_i) begin
      data_mem[lk_idx_i][lk_sel_i*DATA_W +: DATA_W] <= wr_word_data_i;
    end
  end

  assign lk_line  = data_mem[lk_idx_i];
  assign lk_hit_o = valid_q[lk_idx_i] && (tag_mem[lk_idx_i] == lk_tag_i);

  wtc_word_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mux (
    .line_i (lk_line),
    .sel_i  (lk_sel_i),
    .word_o (lk_word_o)
  );
endmodule

// File: rtl/wtc_fill_ctrl.sv
module wtc_fill_ctrl
  import wtc_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int TAG_W  = 16,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2,
  parameter int BYTE_W = 2,
  localparam int WORDS  = 1 << SEL_W,
  localparam int LINE_W = WORDS * DATA_W,
  localparam int ADDR_W = TAG_W + IDX_W + SEL_W + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              busy_o,
  output logic              mem_rd_valid_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_ready_i,
  input  logic              mem_rdata_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fill_en_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output logic [LINE_W-1:0] fill_line_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(WORDS - 1);

  fill_state_e       state_q, state_d;
  logic [SEL_W-1:0]  cnt_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] buf_q [WORDS];
  logic              take;

  assign take = (state_q == FS_WAIT) && mem_rdata_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE: if (start_i) state_d = FS_REQ;
      FS_REQ:  if (mem_rd_ready_i) state_d = FS_WAIT;
      FS_WAIT: if (mem_rdata_valid_i) state_d = (cnt_q == LAST) ? FS_IDLE : FS_REQ;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      tag_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == FS_IDLE && start_i) begin
        cnt_q <= '0;
        tag_q <= tag_i;
        idx_q <= idx_i;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_buf
    always_ff @(posedge clk_i) begin
      if (take && cnt_q == SEL_W'(w)) buf_q[w] <= mem_rdata_i;
    end
    // last word bypasses the buffer so the line installs on its arrival
    assign fill_line_o[w*DATA_W +: DATA_W] = (cnt_q == SEL_W'(w)) ? mem_rdata_i : buf_q[w];
  end

  assign busy_o         = (state_q != FS_IDLE);
  assign mem_rd_valid_o = (state_q == FS_REQ);
  assign mem_rd_addr_o  = {tag_q, idx_q, cnt_q, {BYTE_W{1'b0}}};
  assign fill_en_o      = take && (cnt_q == LAST);
  assign fill_idx_o     = idx_q;
  assign fill_tag_o     = tag_q;
endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 12,
  parameter int SEL_W  = 2,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int TAG_W  = ADDR_W - IDX_W - SEL_W - BYTE_W,
  localparam int WORDS  = 1 << SEL_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_stall_o,
  output logic              cpu_hit_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_rd_valid_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_ready_i,
  input  logic              mem_rdata_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_wr_valid_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_ready_i
);
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [SEL_W-1:0]  a_sel;
  logic [BYTE_W-1:0] unused_byte;

  assign {a_tag, a_idx, a_sel, unused_byte} = cpu_addr_i;

  logic              lk_hit, busy, start, wr_word_en;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [LINE_W-1:0] fill_line;

  assign cpu_hit_o      = cpu_req_i && !busy && lk_hit;
  assign start          = cpu_req_i && !busy && !lk_hit;
  assign mem_wr_valid_o = cpu_hit_o && cpu_we_i;
  assign wr_word_en     = mem_wr_valid_o && mem_wr_ready_i;
  assign cpu_stall_o    = cpu_req_i && !(cpu_hit_o && (!cpu_we_i || mem_wr_ready_i));
  assign mem_wr_addr_o  = {cpu_addr_i[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
  assign mem_wr_data_o  = cpu_wdata_i;

  wtc_line_store #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .lk_idx_i       (a_idx),
    .lk_tag_i       (a_tag),
    .lk_sel_i       (a_sel),
    .lk_hit_o       (lk_hit),
    .lk_word_o      (cpu_rdata_o),
    .wr_word_en_i   (wr_word_en),
    .wr_word_data_i (cpu_wdata_i),
    .fill_en_i      (fill_en),
    .fill_idx_i     (fill_idx),
    .fill_tag_i     (fill_tag),
    .fill_line_i    (fill_line)
  );

  wtc_fill_ctrl #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .BYTE_W(BYTE_W)
  ) u_fill (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .start_i           (start),
    .tag_i             (a_tag),
    .idx_i             (a_idx),
    .busy_o            (busy),
    .mem_rd_valid_o    (mem_rd_valid_o),
    .mem_rd_addr_o     (mem_rd_addr_o),
    .mem_rd_ready_i    (mem_rd_ready_i),
    .mem_rdata_valid_i (mem_rdata_valid_i),
    .mem_rdata_i       (mem_rdata_i),
    .fill_en_o         (fill_en),
    .fill_idx_o        (fill_idx),
    .fill_tag_o        (fill_tag),
    .fill_line_o       (fill_line)
  );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINE_LSB = 4,
  parameter int WORD_LSB = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic              cpu_stall_o,
  input logic              cpu_hit_o,
  input logic              mem_rd_valid_o,
  input logic [ADDR_W-1:0] mem_rd_addr_o,
  input logic              mem_rd_ready_i,
  input logic              mem_wr_valid_o,
  input logic [ADDR_W-1:0] mem_wr_addr_o,
  input logic [DATA_W-1:0] mem_wr_data_o
);
  a_r4_fill_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && mem_rd_valid_o) |-> cpu_stall_o);

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_valid_o && !mem_rd_ready_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

  a_r1_fill_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && mem_rd_valid_o) |->
      (mem_rd_addr_o[ADDR_W-1:LINE_LSB] == cpu_addr_i[ADDR_W-1:LINE_LSB]));

  a_r8_no_fwd_in_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o |-> !mem_wr_valid_o);

  a_r3_hit_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && cpu_hit_o) |-> !cpu_stall_o);

  a_r7_fwd_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o |-> (cpu_we_i &&
      mem_wr_addr_o[ADDR_W-1:WORD_LSB] == cpu_addr_i[ADDR_W-1:WORD_LSB] &&
      mem_wr_data_o == cpu_wdata_i));
endmodule

bind wt_dm_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                               .LINE_LSB(SEL_W + BYTE_W), .WORD_LSB(BYTE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cpu_req_i      (cpu_req_i),
  .cpu_we_i       (cpu_we_i),
  .cpu_addr_i     (cpu_addr_i),
  .cpu_wdata_i    (cpu_wdata_i),
  .cpu_stall_o    (cpu_stall_o),
  .cpu_hit_o      (cpu_hit_o),
  .mem_rd_valid_o (mem_rd_valid_o),
  .mem_rd_addr_o  (mem_rd_addr_o),
  .mem_rd_ready_i (mem_rd_ready_i),
  .mem_wr_valid_o (mem_wr_valid_o),
  .mem_wr_addr_o  (mem_wr_addr_o),
  .mem_wr_data_o  (mem_wr_data_o)
);

// File: tb/tb_wt_dm_cache.sv
module tb_wt_dm_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic        cpu_stall_o, cpu_hit_o;
  logic [31:0] cpu_rdata_o;
  logic        mem_rd_valid_o;
  logic [31:0] mem_rd_addr_o;
  logic        mem_rd_ready_i = 1'b0, mem_rdata_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_wr_valid_o;
  logic [31:0] mem_wr_addr_o, mem_wr_data_o;
  logic        mem_wr_ready_i = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wt_dm_cache dut (.*);

  int n_chk = 0, n_bad = 0;
  int seq = 0;
  int wr_wait = 0;
  int last_fill_seq = 0, last_wr_seq = 0;
  logic [31:0] fill_log [$];
  logic [31:0] wr_addr_log [$];
  logic [31:0] wr_data_log [$];
  logic [31:0] wmem [logic [31:0]];

  function automatic logic [31:0] mem_val(logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return (a * 32'h9E37_79B1) ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read responder: accept, one idle cycle, respond
  initial begin
    int pend;
    logic [31:0] a;
    pend = 0; a = '0;
    forever begin
      @(negedge clk_i);
      mem_rdata_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rdata_valid_i = 1'b1;
          mem_rdata_i = mem_val(a);
        end
      end else if (mem_rd_ready_i) begin
        mem_rd_ready_i = 1'b0;
        pend = 2;
        seq++;
        last_fill_seq = seq;
        fill_log.push_back(a);
      end else if (mem_rd_valid_o) begin
        mem_rd_ready_i = 1'b1;
        a = mem_rd_addr_o;
      end
    end
  end

  // write port: ready after wr_wait cycles of a pending offer
  initial begin
    int w;
    w = 0;
    forever begin
      @(negedge clk_i);
      mem_wr_ready_i = 1'b0;
      if (mem_wr_valid_o) begin
        if (w < wr_wait) w++;
        else begin
          mem_wr_ready_i = 1'b1;
          w = 0;
          seq++;
          last_wr_seq = seq;
          wr_addr_log.push_back(mem_wr_addr_o);
          wr_data_log.push_back(mem_wr_data_o);
          wmem[mem_wr_addr_o] = mem_wr_data_o;
        end
      end else w = 0;
    end
  end

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output bit hit, output int stalls,
                        output bit first_hit);
    @(posedge clk_i); #1;
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = addr; cpu_wdata_i = wd;
    stalls = 0;
    @(negedge clk_i); #1;
    first_hit = cpu_hit_o;
    while (cpu_stall_o) begin
      stalls++;
      @(negedge clk_i); #1;
    end
    rd = cpu_rdata_o; hit = cpu_hit_o;
    @(posedge clk_i); #1;
    cpu_req_i = 1'b0; cpu_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(!cpu_stall_o && !mem_rd_valid_o && !mem_wr_valid_o, "R2 idle after reset",
        {29'd0, cpu_stall_o, mem_rd_valid_o, mem_wr_valid_o}, 32'd0);
  endtask

  task automatic t_cold_read;
    logic [31:0] rd; bit hit, fh; int st;
    fill_log.delete();
    access(1'b0, 32'h0001_0024, '0, rd, hit, st, fh);
    chk(st > 0 && !fh, "R2 cold access stalls, hit low", st, 1);
    chk(fill_log.size() == 4, "R4 four fill reads", fill_log.size(), 4);
    for (int w = 0; w < 4 && w < fill_log.size(); w++)
      chk(fill_log[w] == (32'h0001_0020 | (w << 2)), "R1 R4 fill address order",
          fill_log[w], 32'h0001_0020 | (w << 2));
    chk(hit && rd == mem_val(32'h0001_0024), "R5 data after fill", rd, mem_val(32'h0001_0024));
  endtask

  task automatic t_warm_read;
    logic [31:0] rd; bit hit, fh; int st;
    fill_log.delete();
    access(1'b0, 32'h0001_0028, '0, rd, hit, st, fh);
    chk(st == 0 && hit && fh, "R3 warm read no stall", st, 0);
    chk(rd == mem_val(32'h0001_0028), "R3 word select", rd, mem_val(32'h0001_0028));
    access(1'b0, 32'h0001_002C, '0, rd, hit, st, fh);
    chk(st == 0 && rd == mem_val(32'h0001_002C), "R3 last word", rd, mem_val(32'h0001_002C));
    access(1'b0, 32'h0001_002B, '0, rd, hit, st, fh);
    chk(st == 0 && rd == mem_val(32'h0001_0028), "R9 byte offset ignored", rd, mem_val(32'h0001_0028));
    chk(fill_log.size() == 0, "R3 no fill on hit", fill_log.size(), 0);
  endtask

  task automatic t_conflict;
    logic [31:0] rd; bit hit, fh; int st;
    fill_log.delete();
    access(1'b0, 32'h0002_0024, '0, rd, hit, st, fh);
    chk(st > 0 && fill_log.size() == 4, "R6 other tag misses", fill_log.size(), 4);
    chk(rd == mem_val(32'h0002_0024), "R6 new line data", rd, mem_val(32'h0002_0024));
    fill_log.delete();
    access(1'b0, 32'h0001_0024, '0, rd, hit, st, fh);
    chk(st > 0 && fill_log.size() == 4, "R6 displaced line misses", fill_log.size(), 4);
    chk(rd == mem_val(32'h0001_0024), "R6 refetched data", rd, mem_val(32'h0001_0024));
  endtask

  task automatic t_write_hit;
    logic [31:0] rd, nb; bit hit, fh; int st;
    nb = mem_val(32'h0001_0028);
    wr_addr_log.delete(); wr_data_log.delete(); fill_log.delete();
    wr_wait = 2;
    access(1'b1, 32'h0001_0025, 32'hDEAD_BEEF, rd, hit, st, fh);
    wr_wait = 0;
    chk(st >= 1 && fill_log.size() == 0, "R7 write hit waits for port", st, 1);
    chk(wr_addr_log.size() == 1 && wr_addr_log[0] == 32'h0001_0024, "R7 forwarded address",
        wr_addr_log.size() > 0 ? wr_addr_log[0] : 32'hX, 32'h0001_0024);
    chk(wr_data_log.size() == 1 && wr_data_log[0] == 32'hDEAD_BEEF, "R7 forwarded data",
        wr_data_log.size() > 0 ? wr_data_log[0] : 32'hX, 32'hDEAD_BEEF);
    access(1'b0, 32'h0001_0024, '0, rd, hit, st, fh);
    chk(st == 0 && rd == 32'hDEAD_BEEF, "R7 word updated", rd, 32'hDEAD_BEEF);
    access(1'b0, 32'h0001_0028, '0, rd, hit, st, fh);
    chk(st == 0 && rd == nb, "R7 neighbour unchanged", rd, nb);
  endtask

  task automatic t_write_miss;
    logic [31:0] rd; bit hit, fh; int st;
    wr_addr_log.delete(); fill_log.delete();
    access(1'b1, 32'h0003_1108, 32'h1234_5678, rd, hit, st, fh);
    chk(fill_log.size() == 4, "R8 write miss fetches line", fill_log.size(), 4);
    chk(wr_addr_log.size() == 1 && last_wr_seq > last_fill_seq, "R8 forward after fill",
        last_wr_seq, last_fill_seq + 1);
    access(1'b0, 32'h0003_1108, '0, rd, hit, st, fh);
    chk(st == 0 && hit && rd == 32'h1234_5678, "R8 merged word", rd, 32'h1234_5678);
    access(1'b0, 32'h0003_1104, '0, rd, hit, st, fh);
    chk(st == 0 && rd == mem_val(32'h0003_1104), "R8 rest of line filled", rd, mem_val(32'h0003_1104));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    t_reset();
    t_cold_read();
    t_warm_read();
    t_conflict();
    t_write_hit();
    t_write_miss();
    repeat (3) @(posedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule